// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the byte-wide command port of a single eight-input programmable interrupt controller. A one-bit address selects between two write decodes. With the address low, bit 4 of the data starts an initialization sequence. If bit 4 is clear, bit 3 chooses between the read/poll/mask-mode command and the end-of-interrupt/rotation command. With the address high, the write goes to the sequencer. It takes the vector base, then the optional cascade word, then the optional mode word. When the sequence is idle, the write loads the interrupt mask instead.

The block keeps the pending (request) register, the in-service register, the mask, the rotating priority offset, the vector base and the mode flags. Pending bits are raised and dropped through two per-line pulse vectors. A per-line trigger-mode vector marks which lines are level sensitive. A read returns the pending, in-service or mask register. When a poll is armed, the read instead returns the number of the line being acknowledged, and the acknowledge takes effect on that same clock edge. All register writes take effect on the rising clock edge. Read data is a combinational function of the registered state and the address. Cascade wiring between controllers is not part of this block.

Top module: `irqc_regif`

## Requirements
- R1: After reset, all of these are zero: mask, in-service, pending, offset, vector base and every mode flag. The sequencer is idle, so `init_busy` is 0.
- R2: A write with `addr`=0 and `wdata[4]`=1 starts initialization. It clears the mask, in-service bits, offset, rotate-on-auto-EOI, special mask, read-select and poll. Of the pending bits it keeps only those whose `level_sel` bit is 1, and it ignores `irr_set` and `irr_clr` in that cycle.
- R3: If `wdata[0]` of the initialization start word is 0, auto-EOI and special nested mode are cleared. If it is 1, both flags keep their values.
- R4: The next `addr`=1 write after the start word loads the vector base with `wdata & 8'hF8`. The sequencer then expects the cascade word only if the start word had `wdata[1]`=0. It expects the mode word only if the start word had `wdata[0]`=1. Otherwise it returns to idle. `init_busy` is 1 whenever the sequencer is not idle.
- R5: The mode word sets special nested mode from `wdata[4]` and auto-EOI from `wdata[1]`, then returns the sequencer to idle.
- R6: An `addr`=1 write while the sequencer is idle loads the mask with `wdata`.
- R7: A write with `addr`=0, `wdata[4]`=0 and `wdata[3]`=1 behaves as follows. If `wdata[2]` is 1, poll is armed. If `wdata[1]` is 1, read-select is loaded from `wdata[0]`. If `wdata[6]` is 1, special mask mode is loaded from `wdata[5]`. A cleared enable bit leaves the matching flag unchanged.
- R8: A write with `addr`=0 and `wdata[4:3]`=0 carries a command in `wdata[7:5]`. Code 0 clears rotate-on-auto-EOI and code 4 sets it. Code 6 sets the offset to `wdata[2:0]`+1 mod 8. Code 2 changes nothing.
- R9: Codes 1 and 5 clear the highest-priority in-service bit. In special mask mode, in-service bits that are masked are skipped. If no bit qualifies, nothing changes. Code 5 then sets the offset to that line plus 1 mod 8.
- R10: Codes 3 and 7 clear in-service bit `wdata[2:0]`. Code 7 then sets the offset to `wdata[2:0]`+1 mod 8.
- R11: Without poll, a read with `addr`=1 returns the mask. A read with `addr`=0 returns the in-service register when read-select is 1, and the pending register otherwise.
- R12: A read while poll is armed clears poll. If a line is granted, the read returns its number (0..7) and the clock edge does three things. It drops the line's pending bit if the line is edge triggered. It sets the line's in-service bit unless auto-EOI is on. With auto-EOI and rotate-on-auto-EOI both on, it sets the offset to the line plus 1 mod 8. If no line is granted, the read returns 8'hFF.
- R13: Priority rank of line i is (i − offset) mod 8, and rank 0 is highest. A line is granted when it is the best-ranked unmasked pending line and its rank is strictly better than the best in-service rank. In special mask mode, masked in-service bits are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only when poll is armed) |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irr_set | input | 8 | Per-line pulses that raise pending bits |
| irr_clr | input | 8 | Per-line pulses that drop pending bits |
| level_sel | input | 8 | Per-line trigger mode, 1 = level |
| vec_base | output | 8 | Vector base loaded during initialization |
| prio_offset | output | 3 | Current priority rotation offset |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| nest_special | output | 1 | Special nested mode flag |
| rotate_aeoi | output | 1 | Rotate on auto-EOI flag |
| special_mask | output | 1 | Special mask mode flag |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, and one property checks this input rule directly. The EOI and poll properties assume that the line count is a power of two, which holds for the default of eight lines. The stimulus issues exactly one strobe per vector and leaves idle vectors between accesses. It changes `level_sel` only between vectors, never while a poll read is in flight. As a result, every edge has exactly one decode path active and the reference model applies the same single action.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  localparam logic [2:0] OP_ROT_OFF  = 3'd0;
  localparam logic [2:0] OP_NS_EOI   = 3'd1;
  localparam logic [2:0] OP_SP_EOI   = 3'd3;
  localparam logic [2:0] OP_ROT_ON   = 3'd4;
  localparam logic [2:0] OP_NS_ROT   = 3'd5;
  localparam logic [2:0] OP_SET_PRIO = 3'd6;
  localparam logic [2:0] OP_SP_ROT   = 3'd7;
endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N_IRQ = 8,
  parameter int IW    = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] mask,
  input  logic [IW-1:0]    offset,
  output logic             hit,
  output logic [IW-1:0]    rank,
  output logic [IW-1:0]    line
);
  logic [2*N_IRQ-1:0] dbl;
  logic [N_IRQ-1:0]   rot;

  // bit p of rot is line (p + offset) mod N_IRQ
  assign dbl = {mask, mask} >> offset;
  assign rot = dbl[N_IRQ-1:0];

  always_comb begin
    hit  = 1'b0;
    rank = '0;
    for (int p = N_IRQ - 1; p >= 0; p--) begin
      if (rot[p]) begin
        hit  = 1'b1;
        rank = IW'(p);
      end
    end
  end

  assign line = rank + offset;
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       single_in,
  input  logic       want_mode_in,
  input  logic       hi_wr,
  output seq_state_e state,
  output logic       mask_stb,
  output logic       base_stb,
  output logic       mode_stb
);
  logic single_q, want_mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      single_q    <= 1'b0;
      want_mode_q <= 1'b0;
    end else if (start) begin
      state       <= SEQ_BASE;
      single_q    <= single_in;
      want_mode_q <= want_mode_in;
    end else if (hi_wr) begin
      unique case (state)
        SEQ_BASE: state <= !single_q ? SEQ_CASC : (want_mode_q ? SEQ_MODE : SEQ_IDLE);
        SEQ_CASC: state <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign mask_stb = hi_wr && (state == SEQ_IDLE);
  assign base_stb = hi_wr && (state == SEQ_BASE);
  assign mode_stb = hi_wr && (state == SEQ_MODE);
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic                       addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  input  logic [N_IRQ-1:0]           irr_set,
  input  logic [N_IRQ-1:0]           irr_clr,
  input  logic [N_IRQ-1:0]           level_sel,
  output logic [DW-1:0]              vec_base,
  output logic [$clog2(N_IRQ)-1:0]   prio_offset,
  output logic                       auto_eoi,
  output logic                       nest_special,
  output logic                       rotate_aeoi,
  output logic                       special_mask
  ,output logic                      init_busy
);
  localparam int IW = $clog2(N_IRQ);
  localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << IW) - 1);

  logic [N_IRQ-1:0] irr_q, isr_q, imr_q, irr_n, isr_n, imr_n;
  logic [IW-1:0]    off_q, off_n;
  logic [DW-1:0]    base_q, base_n;
  logic aeoi_q, sfn_q, rot_q, smm_q, rsel_q, poll_q;
  logic aeoi_n, sfn_n, rot_n, smm_n, rsel_n, poll_n;

  seq_state_e seq_state;
  logic       mask_stb, base_stb, mode_stb;

  logic       lo_wr, hi_wr, cmd_init, cmd_misc, cmd_eoi;
  logic [2:0] opc;
  logic [IW-1:0] sel_line;

  assign lo_wr    = wr_en && !addr;
  assign hi_wr    = wr_en && addr;
  assign cmd_init = lo_wr && wdata[4];
  assign cmd_misc = lo_wr && !wdata[4] && wdata[3];
  assign cmd_eoi  = lo_wr && !wdata[4] && !wdata[3];
  assign opc      = wdata[7:5];
  assign sel_line = wdata[IW-1:0];

  irqc_init_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (cmd_init),
    .single_in    (wdata[1]),
    .want_mode_in (wdata[0]),
    .hi_wr        (hi_wr),
    .state        (seq_state),
    .mask_stb     (mask_stb),
    .base_stb     (base_stb),
    .mode_stb     (mode_stb)
  );

  // pending side and in-service side share one picker design
  logic [N_IRQ-1:0] req_mask, svc_mask;
  logic             req_hit, svc_hit, grant;
  logic [IW-1:0]    req_rank, req_line, svc_rank, svc_line;

  assign req_mask = irr_q & ~imr_q;
  assign svc_mask = smm_q ? (isr_q & ~imr_q) : isr_q;

  irqc_prio_pick #(.N_IRQ(N_IRQ), .IW(IW)) u_req (
    .mask(req_mask), .offset(off_q), .hit(req_hit), .rank(req_rank), .line(req_line)
  );
  irqc_prio_pick #(.N_IRQ(N_IRQ), .IW(IW)) u_svc (
    .mask(svc_mask), .offset(off_q), .hit(svc_hit), .rank(svc_rank), .line(svc_line)
  );

  assign grant = req_hit && (!svc_hit || (req_rank < svc_rank));

  always_comb begin
    if (poll_q)
      rdata = grant ? DW'(req_line) : {DW{1'b1}};
    else if (addr)
      rdata = DW'(imr_q);
    else
      rdata = rsel_q ? DW'(isr_q) : DW'(irr_q);
  end

  always_comb begin
    irr_n  = (irr_q | irr_set) & ~irr_clr;
    isr_n  = isr_q;
    imr_n  = imr_q;
    off_n  = off_q;
    base_n = base_q;
    aeoi_n = aeoi_q;
    sfn_n  = sfn_q;
    rot_n  = rot_q;
    smm_n  = smm_q;
    rsel_n = rsel_q;
    poll_n = poll_q;
    if (cmd_init) begin
      irr_n  = irr_q & level_sel;
      isr_n  = '0;
      imr_n  = '0;
      off_n  = '0;
      rot_n  = 1'b0;
      smm_n  = 1'b0;
      rsel_n = 1'b0;
      poll_n = 1'b0;
      if (!wdata[0]) begin
        aeoi_n = 1'b0;
        sfn_n  = 1'b0;
      end
    end else if (cmd_misc) begin
      if (wdata[2]) poll_n = 1'b1;
      if (wdata[1]) rsel_n = wdata[0];
      if (wdata[6]) smm_n  = wdata[5];
    end else if (cmd_eoi) begin
      unique case (opc)
        OP_ROT_OFF:  rot_n = 1'b0;
        OP_ROT_ON:   rot_n = 1'b1;
        OP_SET_PRIO: off_n = sel_line + IW'(1);
        OP_NS_EOI, OP_NS_ROT: begin
          if (svc_hit) begin
            isr_n[svc_line] = 1'b0;
            if (opc == OP_NS_ROT) off_n = svc_line + IW'(1);
          end
        end
        OP_SP_EOI, OP_SP_ROT: begin
          isr_n[sel_line] = 1'b0;
          if (opc == OP_SP_ROT) off_n = sel_line + IW'(1);
        end
        default: ;
      endcase
    end else if (mask_stb) begin
      imr_n = wdata[N_IRQ-1:0];
    end else if (base_stb) begin
      base_n = wdata & BASE_KEEP;
    end else if (mode_stb) begin
      sfn_n  = wdata[4];
      aeoi_n = wdata[1];
    end

    if (rd_en && poll_q) begin
      poll_n = 1'b0;
      if (grant) begin
        if (!level_sel[req_line]) irr_n[req_line] = 1'b0;
        if (!aeoi_q)    isr_n[req_line] = 1'b1;
        else if (rot_q) off_n = req_line + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      off_q  <= '0;
      base_q <= '0;
      aeoi_q <= 1'b0;
      sfn_q  <= 1'b0;
      rot_q  <= 1'b0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      imr_q  <= imr_n;
      off_q  <= off_n;
      base_q <= base_n;
      aeoi_q <= aeoi_n;
      sfn_q  <= sfn_n;
      rot_q  <= rot_n;
      smm_q  <= smm_n;
      rsel_q <= rsel_n;
      poll_q <= poll_n;
    end
  end

  assign vec_base     = base_q;
  assign prio_offset  = off_q;
  assign auto_eoi     = aeoi_q;
  assign nest_special = sfn_q;
  assign rotate_aeoi  = rot_q;
  assign special_mask = smm_q;
  assign init_busy    = (seq_state != SEQ_IDLE);
endmodule

// File: rtl/irqc_regif_chk.sv
module irqc_regif_chk
  import irqc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     addr,
  input logic [DW-1:0]            wdata,
  input logic [N_IRQ-1:0]         imr,
  input logic [N_IRQ-1:0]         isr,
  input logic [$clog2(N_IRQ)-1:0] offset,
  input logic [DW-1:0]            base,
  input logic                     poll,
  input seq_state_e               seq_state
);
  localparam int IW = $clog2(N_IRQ);
  localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << IW) - 1);

  // input rule: one strobe per cycle (R11 read path, R2 write path)
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (imr == '0 && isr == '0 && offset == '0 && !poll));

  a_r4_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && seq_state == SEQ_BASE) |=> (base == ($past(wdata) & BASE_KEEP)));

  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr && seq_state == SEQ_BASE)) |=> $stable(base));

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && seq_state == SEQ_IDLE) |=> (imr == $past(wdata[N_IRQ-1:0])));

  a_r7_poll_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && !wdata[4] && wdata[3] && wdata[2]) |=> poll);

  a_r10_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[6:5] == 2'b11)
      |=> !isr[$past(wdata[IW-1:0])]);

  a_r12_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll) |=> !poll);
endmodule

bind irqc_regif irqc_regif_chk #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .imr       (imr_q),
  .isr       (isr_q),
  .offset    (off_q),
  .base      (base_q),
  .poll      (poll_q),
  .seq_state (seq_state)
);

// File: tb/irqc_regif_test.sv
module irqc_regif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr_set = '0, irr_clr = '0;
  logic [7:0] level_sel = 8'h10;
  logic [7:0] rdata, vec_base;
  logic [2:0] prio_offset;
  logic       auto_eoi, nest_special, rotate_aeoi, special_mask, init_busy;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irqc_regif uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irr_set(irr_set), .irr_clr(irr_clr),
    .level_sel(level_sel), .vec_base(vec_base), .prio_offset(prio_offset),
    .auto_eoi(auto_eoi), .nest_special(nest_special), .rotate_aeoi(rotate_aeoi),
    .special_mask(special_mask), .init_busy(init_busy)
  );

  // behavioural reference state
  bit [7:0] m_irr, m_isr, m_imr, m_base;
  int       m_off, m_st;
  bit       m_aeoi, m_sfn, m_rot, m_smm, m_rsel, m_poll, m_single, m_mode;

  function automatic int best(bit [7:0] m);
    for (int r = 0; r < 8; r++)
      if (m[(r + m_off) % 8]) return r;
    return 8;
  endfunction

  function automatic bit [7:0] svc_view();
    return m_smm ? (m_isr & ~m_imr) : m_isr;
  endfunction

  function automatic bit [7:0] exp_rdata(bit a0);
    int r, s;
    if (m_poll) begin
      r = best(m_irr & ~m_imr);
      s = best(svc_view());
      if (r < 8 && r < s) return 8'((r + m_off) % 8);
      return 8'hFF;
    end
    if (a0) return m_imr;
    return m_rsel ? m_isr : m_irr;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit wr, bit rd, bit a0, bit [7:0] d, bit [7:0] st, bit [7:0] cl);
    bit [7:0] irr_n;
    int r, s, q, g;
    r = best(m_irr & ~m_imr);
    s = best(svc_view());
    g = (r < 8 && r < s) ? (r + m_off) % 8 : -1;
    irr_n = (m_irr | st) & ~cl;
    if (wr && !a0 && d[4]) begin
      irr_n = m_irr & level_sel;
      m_imr = 0; m_isr = 0; m_off = 0; m_rot = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
      if (!d[0]) begin m_aeoi = 0; m_sfn = 0; end
      m_st = 1; m_single = d[1]; m_mode = d[0];
    end else if (wr && !a0 && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (wr && !a0) begin
      case (int'(d[7:5]))
        0: m_rot = 0;
        4: m_rot = 1;
        6: m_off = (int'(d[2:0]) + 1) % 8;
        1, 5: if (s < 8) begin
          q = (s + m_off) % 8;
          m_isr[q] = 0;
          if (d[7:5] == 3'd5) m_off = (q + 1) % 8;
        end
        3, 7: begin
          m_isr[d[2:0]] = 0;
          if (d[7:5] == 3'd7) m_off = (int'(d[2:0]) + 1) % 8;
        end
        default: ;
      endcase
    end else if (wr && a0) begin
      case (m_st)
        0: m_imr = d;
        1: begin m_base = d & 8'hF8; m_st = !m_single ? 2 : (m_mode ? 3 : 0); end
        2: m_st = m_mode ? 3 : 0;
        default: begin m_sfn = d[4]; m_aeoi = d[1]; m_st = 0; end
      endcase
    end
    if (rd && m_poll) begin
      m_poll = 0;
      if (g >= 0) begin
        if (!level_sel[g]) irr_n[g] = 0;
        if (!m_aeoi) m_isr[g] = 1;
        else if (m_rot) m_off = (g + 1) % 8;
      end
    end
    m_irr = irr_n;
  endtask

  // one vector: drive at negedge, compare before the edge, advance model
  task automatic vec(string req, bit wr, bit rd, bit a0, bit [7:0] d,
                     bit [7:0] st = 0, bit [7:0] cl = 0);
    wr_en = wr; rd_en = rd; addr = a0; wdata = d; irr_set = st; irr_clr = cl;
    #1;
    check(req, "rdata",        rdata,        exp_rdata(a0));
    check(req, "vec_base",     vec_base,     m_base);
    check(req, "prio_offset",  prio_offset,  m_off);
    check(req, "auto_eoi",     auto_eoi,     m_aeoi);
    check(req, "nest_special", nest_special, m_sfn);
    check(req, "rotate_aeoi",  rotate_aeoi,  m_rot);
    check(req, "special_mask", special_mask, m_smm);
    check(req, "init_busy",    init_busy,    m_st != 0);
    model_step(wr, rd, a0, d, st, cl);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wlo(string req, bit [7:0] d); vec(req, 1, 0, 0, d); endtask
  task automatic whi(string req, bit [7:0] d); vec(req, 1, 0, 1, d); endtask
  task automatic rd(string req, bit a0);       vec(req, 0, 1, a0, 8'h00); endtask
  task automatic idle(string req);             vec(req, 0, 0, 0, 8'h00); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1"); rd("R1", 0); rd("R1", 1);

    // R4/R5: single, mode word requested
    wlo("R2", 8'h13); whi("R4", 8'h45); whi("R5", 8'h12); idle("R5");
    // R3: start without mode word clears auto-EOI and special nested; cascade path
    wlo("R3", 8'h10); whi("R4", 8'h88); idle("R4"); whi("R4", 8'h04); idle("R4");
    wlo("R4", 8'h11); whi("R4", 8'h20); whi("R4", 8'h00); whi("R5", 8'h02); idle("R5");
    wlo("R3", 8'h11); idle("R3");
    whi("R4", 8'h08); whi("R4", 8'h00); whi("R5", 8'h00); idle("R5");

    // R6/R11: mask write and readback
    whi("R6", 8'h81); rd("R11", 1); whi("R6", 8'h00); rd("R11", 1);

    // R11/R12/R13: pending lines 2 (edge) and 4 (level)
    vec("R11", 0, 0, 0, 8'h00, 8'h14); rd("R11", 0);
    wlo("R7", 8'h0C); rd("R12", 0); idle("R12");
    wlo("R7", 8'h0B); rd("R11", 0);
    wlo("R7", 8'h0C); rd("R13", 0);
    wlo("R9", 8'h20); rd("R11", 0);
    wlo("R7", 8'h0C); rd("R12", 0); rd("R11", 0);
    wlo("R7", 8'h0A); rd("R12", 0);

    // R9: special mask mode skips masked in-service bits
    vec("R9", 0, 0, 0, 8'h00, 8'h42);
    whi("R6", 8'h10);
    wlo("R7", 8'h68); wlo("R7", 8'h0E); rd("R13", 0); rd("R11", 0);
    wlo("R9", 8'h20); rd("R9", 0);
    wlo("R9", 8'h20); rd("R9", 0);
    wlo("R7", 8'h48); wlo("R9", 8'h20); rd("R9", 0);

    // R10: specific EOI with and without rotation
    wlo("R7", 8'h0C); rd("R12", 0); rd("R10", 0);
    wlo("R10", 8'h66); rd("R10", 0);
    wlo("R10", 8'hE5); idle("R10");

    // R8: rotation flag, set priority, no-op code
    wlo("R8", 8'hC2); wlo("R8", 8'h80); idle("R8"); wlo("R8", 8'h00); wlo("R8", 8'h40); idle("R8");

    // R13: rotated priority with offset 3, then rotate on non-specific EOI
    vec("R13", 0, 0, 0, 8'h00, 8'h21);
    wlo("R7", 8'h0C); rd("R13", 0);
    wlo("R9", 8'hA0); idle("R9");
    wlo("R7", 8'h0C); rd("R13", 0); rd("R11", 0);
    wlo("R7", 8'h09); rd("R7", 0);

    // R2/R12: restart keeps level line, auto-EOI with rotation
    wlo("R2", 8'h13); rd("R2", 0); whi("R4", 8'h00); whi("R5", 8'h02);
    rd("R2", 1);
    wlo("R7", 8'h0C); rd("R12", 0); wlo("R7", 8'h0B); rd("R12", 0);
    wlo("R8", 8'h80);
    wlo("R7", 8'h0C); rd("R12", 0); idle("R12");
    vec("R12", 0, 0, 0, 8'h00, 8'h00, 8'hFF);
    wlo("R7", 8'h0C); rd("R12", 0); rd("R12", 0);

    // R1: reset returns everything to zero
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_off = 0; m_st = 0;
    m_aeoi = 0; m_sfn = 0; m_rot = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
    m_single = 0; m_mode = 0;
    idle("R1"); rd("R1", 0); rd("R1", 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule